// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block turns a 14-bit sample word into the control bits for a current-steering converter core that is split into three sections of different weight. The five most significant bits drive 31 equal switches, each worth 512 LSB, through a thermometer code. The next four bits drive 15 equal switches, each worth 32 LSB, also through a thermometer code. The five least significant bits go straight through to five binary-weighted switches worth 1, 2, 4, 8 and 16 LSB.

The word is first captured in an input register. All decoding is done between that register and one wide switch register that holds all 51 controls. Every switch therefore moves on the same clock edge, with no decode skew at the core. Each control is delivered as a true/complement pair, so each cell always steers its current to one of its two outputs and is never switched off. The asynchronous active-low reset is applied at once and is released through a two-stage synchronizer.

Top module: `seg_dac_decoder`

## Requirements
- R1: The switch outputs seen after clock edge n reflect the word on `code_i` at edge n-1. This is two register stages, so a new word shows up two edges after it is presented.
- R2: For a top field value v = `code_i[13:9]`, `top_o` bits 0 to v-1 are 1 and all other bits are 0.
- R3: For a middle field value v = `code_i[8:5]`, `mid_o` bits 0 to v-1 are 1 and all other bits are 0.
- R4: `bin_o[i]` equals `code_i[i]` for i = 0..4. Bit i carries weight 2^i LSB.
- R5: 512 × (ones in `top_o`) + 32 × (ones in `mid_o`) + the value of `bin_o` equals the word that was captured.
- R6: Outside reset, every complement output is the bitwise inverse of its true output on every cycle: `top_n_o`, `mid_n_o` and `bin_n_o` against `top_o`, `mid_o` and `bin_o`.
- R7: When `rst_n` goes low, all true outputs clear to 0 and all complement outputs set to 1 at once, with no clock needed. They stay that way while reset is held.
- R8: While the input word is held constant, none of the 102 switch outputs changes.
- R9: The all-zero word gives all true outputs 0. The word 0x3FFF gives all 51 true outputs 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| code_i | input | 14 | Sample word, unsigned |
| top_o | output | 31 | Top-segment thermometer controls, 512 LSB each |
| top_n_o | output | 31 | Complements of `top_o` |
| mid_o | output | 15 | Middle-segment thermometer controls, 32 LSB each |
| mid_n_o | output | 15 | Complements of `mid_o` |
| bin_o | output | 5 | Binary-weighted controls, bit i worth 2^i LSB |
| bin_n_o | output | 5 | Complements of `bin_o` |

## Verification
A stuck or misdecoded thermometer line shows up two edges after the offending word is presented. It appears either as a gap in the contiguous run of ones or as a weighted sum that differs from the input by a multiple of 32 or 512. A mismatch between the two register stages shows up as output from the wrong word, or as outputs that move while the input is held. A broken complement register breaks the pair relation on the same cycle. The random words are mixed with segment-boundary words such as 0x01E0, 0x0200 and 0x3E00, so that each carry between sections is observed.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

  function automatic int therm_lines(input int field_w);
    return (1 << field_w) - 1;
  endfunction

  function automatic int line_weight(input int lower_w);
    return 1 << lower_w;
  endfunction

endpackage

// File: rtl/seg_dac_rst_sync.sv
module seg_dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/seg_dac_therm_dec.sv
module seg_dac_therm_dec #(
  parameter int IN_W = 5
) (
  input  logic [IN_W-1:0]          val_i,
  output logic [(2**IN_W)-2:0]     line_o
);

  localparam int LINES = (2**IN_W) - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign line_o[g] = (val_i > IN_W'(g));
  end

endmodule

// File: rtl/seg_dac_pair_reg.sv
module seg_dac_pair_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_n_o
);

  logic [W-1:0] pos_d;
  logic [W-1:0] neg_d;
  logic [W-1:0] pos_q;
  logic [W-1:0] neg_q;

  always_comb begin
    pos_d = d_i;
    neg_d = ~d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      neg_q <= '1;
    end else begin
      pos_q <= pos_d;
      neg_q <= neg_d;
    end
  end

  assign q_o   = pos_q;
  assign q_n_o = neg_q;

endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_dac_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int TOP_W  = 5,
  parameter int MID_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       code_i,
  output logic [(2**TOP_W)-2:0]   top_o,
  output logic [(2**TOP_W)-2:0]   top_n_o,
  output logic [(2**MID_W)-2:0]   mid_o,
  output logic [(2**MID_W)-2:0]   mid_n_o,
  output logic [DATA_W-TOP_W-MID_W-1:0] bin_o,
  output logic [DATA_W-TOP_W-MID_W-1:0] bin_n_o
);

  localparam int BIN_W     = DATA_W - TOP_W - MID_W;
  localparam int TOP_LINES = therm_lines(TOP_W);
  localparam int MID_LINES = therm_lines(MID_W);
  localparam int SW_W      = TOP_LINES + MID_LINES + BIN_W;

  logic rst_n_int;

  seg_dac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Stage 1: input word capture
  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] word_q;

  always_comb begin
    word_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  // Segment split
  logic [TOP_W-1:0] top_fld;
  logic [MID_W-1:0] mid_fld;
  logic [BIN_W-1:0] bin_fld;

  assign top_fld = word_q[DATA_W-1 -: TOP_W];
  assign mid_fld = word_q[BIN_W +: MID_W];
  assign bin_fld = word_q[BIN_W-1:0];

  // Decode ahead of the switch register
  logic [TOP_LINES-1:0] top_dec;
  logic [MID_LINES-1:0] mid_dec;

  seg_dac_therm_dec #(.IN_W(TOP_W)) u_top_dec (
    .val_i  (top_fld),
    .line_o (top_dec)
  );

  seg_dac_therm_dec #(.IN_W(MID_W)) u_mid_dec (
    .val_i  (mid_fld),
    .line_o (mid_dec)
  );

  // Stage 2: one wide register for every switch pair
  logic [SW_W-1:0] sw_d;
  logic [SW_W-1:0] sw_q;
  logic [SW_W-1:0] sw_n_q;

  always_comb begin
    sw_d = {top_dec, mid_dec, bin_fld};
  end

  seg_dac_pair_reg #(.W(SW_W)) u_sw_reg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (sw_d),
    .q_o   (sw_q),
    .q_n_o (sw_n_q)
  );

  assign top_o   = sw_q  [SW_W-1 -: TOP_LINES];
  assign top_n_o = sw_n_q[SW_W-1 -: TOP_LINES];
  assign mid_o   = sw_q  [BIN_W +: MID_LINES];
  assign mid_n_o = sw_n_q[BIN_W +: MID_LINES];
  assign bin_o   = sw_q  [BIN_W-1:0];
  assign bin_n_o = sw_n_q[BIN_W-1:0];

endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
  parameter int DATA_W = 14,
  parameter int TOP_W  = 5,
  parameter int MID_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DATA_W-1:0]       code_i,
  input logic [(2**TOP_W)-2:0]   top_o,
  input logic [(2**TOP_W)-2:0]   top_n_o,
  input logic [(2**MID_W)-2:0]   mid_o,
  input logic [(2**MID_W)-2:0]   mid_n_o,
  input logic [DATA_W-TOP_W-MID_W-1:0] bin_o,
  input logic [DATA_W-TOP_W-MID_W-1:0] bin_n_o
);

  localparam int BIN_W = DATA_W - TOP_W - MID_W;

  logic [2:0] warm_q;
  logic [1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_q != 3'd7) begin
      warm_q <= warm_q + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      low_q <= '0;
    end else if (low_q != 2'd3) begin
      low_q <= low_q + 2'd1;
    end
  end

  logic warm;
  assign warm = (warm_q == 3'd7);

  int weighted;
  assign weighted = $countones(top_o) * (1 << (MID_W + BIN_W))
                  + $countones(mid_o) * (1 << BIN_W)
                  + int'(bin_o);

  // R6
  a_r6_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (top_n_o == ~top_o) && (mid_n_o == ~mid_o) && (bin_n_o == ~bin_o));

  // R2
  a_r2_top_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> ((top_o & (top_o + 1'b1)) == '0));

  // R3
  a_r3_mid_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> ((mid_o & (mid_o + 1'b1)) == '0));

  // R5, R1
  a_r5_weight_sum: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (weighted == int'($past(code_i, 2))));

  // R8
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ($past(code_i, 2) == $past(code_i, 3))) |->
      ($stable(top_o) && $stable(mid_o) && $stable(bin_o) &&
       $stable(top_n_o) && $stable(mid_n_o) && $stable(bin_n_o)));

  // R7
  a_r7_reset_state: assert property (@(posedge clk)
    (!rst_n && low_q == 2'd3) |->
      (top_o == '0 && mid_o == '0 && bin_o == '0 &&
       top_n_o == '1 && mid_n_o == '1 && bin_n_o == '1));

endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(
  .DATA_W (DATA_W),
  .TOP_W  (TOP_W),
  .MID_W  (MID_W)
) u_chk (.*);

// File: tb/seg_dac_decoder_tb.sv
module seg_dac_decoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic [13:0] code_i;
  logic [30:0] top_o, top_n_o;
  logic [14:0] mid_o, mid_n_o;
  logic [4:0]  bin_o, bin_n_o;

  int total = 0;
  int bad   = 0;
  logic [13:0] h1, h2;

  seg_dac_decoder dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_i  (code_i),
    .top_o   (top_o),
    .top_n_o (top_n_o),
    .mid_o   (mid_o),
    .mid_n_o (mid_n_o),
    .bin_o   (bin_o),
    .bin_n_o (bin_n_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [30:0] exp_top(input logic [13:0] c);
    logic [30:0] r;
    for (int i = 0; i < 31; i++) r[i] = (i < int'(c[13:9]));
    return r;
  endfunction

  function automatic logic [14:0] exp_mid(input logic [13:0] c);
    logic [14:0] r;
    for (int i = 0; i < 15; i++) r[i] = (i < int'(c[8:5]));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk(top_o == '0 && mid_o == '0 && bin_o == '0, {tag, " true"},
        {13'd0, top_o, mid_o, bin_o}, 64'd0);
    chk(top_n_o == '1 && mid_n_o == '1 && bin_n_o == '1, {tag, " comp"},
        {13'd0, top_n_o, mid_n_o, bin_n_o}, {13'd0, 51'h7FFFFFFFFFFFF});
  endtask

  task automatic compare(input logic [13:0] c);
    int w;
    chk({top_o, mid_o, bin_o} == {exp_top(c), exp_mid(c), c[4:0]}, "R1 latency",
        {13'd0, top_o, mid_o, bin_o}, {13'd0, exp_top(c), exp_mid(c), c[4:0]});
    chk(top_o == exp_top(c), "R2 top therm", 64'(top_o), 64'(exp_top(c)));
    chk(mid_o == exp_mid(c), "R3 mid therm", 64'(mid_o), 64'(exp_mid(c)));
    chk(bin_o == c[4:0], "R4 binary", 64'(bin_o), 64'(c[4:0]));
    w = $countones(top_o) * 512 + $countones(mid_o) * 32 + int'(bin_o);
    chk(w == int'(c), "R5 weight sum", 64'(w), 64'(c));
    chk(top_n_o == ~top_o && mid_n_o == ~mid_o && bin_n_o == ~bin_o, "R6 pairs",
        {13'd0, top_n_o, mid_n_o, bin_n_o}, {13'd0, ~top_o, ~mid_o, ~bin_o});
  endtask

  task automatic step(input logic [13:0] nc);
    @(negedge clk);
    compare(h2);
    code_i = nc;
    h2 = h1;
    h1 = nc;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [30:0] snap_t;
    logic [14:0] snap_m;
    logic [4:0]  snap_b;
    void'($urandom(32'd2024));
    rst_n  = 1'b0;
    code_i = 14'h1ABC;
    h1 = '0;
    h2 = '0;
    repeat (4) @(negedge clk);
    check_reset_state("R7 reset");
    rst_n  = 1'b1;
    code_i = '0;
    repeat (4) step(14'h0000);

    // R9 and segment boundaries
    step(14'h3FFF);
    step(14'h0000);
    step(14'h3E00);
    step(14'h01E0);
    step(14'h001F);
    step(14'h0200);
    step(14'h0020);
    step(14'h0001);
    step(14'h01FF);
    step(14'h3DFF);
    step(14'h3FFF);
    step(14'h3FFF);
    step(14'h0000);
    step(14'h0000);
    @(negedge clk);
    chk(top_o == '0 && mid_o == '0 && bin_o == '0, "R9 zero word",
        {13'd0, top_o, mid_o, bin_o}, 64'd0);
    code_i = 14'h3FFF; h2 = h1; h1 = 14'h3FFF;
    step(14'h3FFF);
    step(14'h3FFF);
    chk(top_o == '1 && mid_o == '1 && bin_o == '1, "R9 full word",
        {13'd0, top_o, mid_o, bin_o}, {13'd0, 51'h7FFFFFFFFFFFF});

    // R8 hold
    repeat (3) step(14'h2A5C);
    snap_t = top_o; snap_m = mid_o; snap_b = bin_o;
    for (int k = 0; k < 4; k++) begin
      step(14'h2A5C);
      chk(top_o == snap_t && mid_o == snap_m && bin_o == snap_b, "R8 hold",
          {13'd0, top_o, mid_o, bin_o}, {13'd0, snap_t, snap_m, snap_b});
    end

    // random words
    for (int k = 0; k < 3000; k++) step(14'($urandom));

    // R7 asynchronous reset mid-run
    @(negedge clk);
    compare(h2);
    rst_n = 1'b0;
    #1;
    check_reset_state("R7 async");
    @(negedge clk);
    check_reset_state("R7 held");
    rst_n  = 1'b1;
    code_i = '0;
    h1 = '0;
    h2 = '0;
    repeat (4) step(14'h0000);
    for (int k = 0; k < 500; k++) step(14'($urandom));
    repeat (2) step(14'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule